// File: doc/BRIEF.md
# Tagged Conversion Result Buffer

This block holds conversion results between a conversion sequencer and a processor. Every result written into it carries a 16-bit sample together with three tags: the command that produced it, the loop iteration, and the trigger that started it. The processor reads the oldest result from a first-word-fall-through port. That port always shows the head entry and a valid flag. A read strobe removes the head entry at the next clock edge. Reading an empty buffer never stalls. It returns the valid flag low.

The block keeps an occupancy count and compares it with a programmable 3-bit threshold to form a level flag. An interrupt line is that flag gated by an enable input, so an interrupt handler silences the line by clearing the enable. A one-cycle flush strobe discards everything pending. A write that finds the buffer full is lost and raises a sticky overflow indication.

Top module: `tagged_result_fifo`

## Requirements
- R1: After reset the occupancy is 0, the valid flag is low, overflow is low, and both the level flag and the interrupt are low.
- R2: Entries leave in the order they were written, and each keeps its 16-bit value, 3-bit command tag, 4-bit loop tag and 2-bit trigger tag unchanged.
- R3: While the occupancy is nonzero, the valid flag is high and the read port shows the oldest entry. A read strobe removes that entry at the next rising edge.
- R4: While the buffer is empty, the valid flag is low. A read strobe on an empty buffer leaves the occupancy at 0.
- R5: A read and a write in the same cycle, when the buffer is neither empty nor full, leave the occupancy unchanged.
- R6: The depth is 8 entries. A write in a cycle that begins with 8 entries is dropped, even if a read happens in the same cycle. The dropped write sets a sticky overflow flag.
- R7: A flush strobe sets the occupancy to 0 and clears overflow at the next edge. Any write or read strobe in that same cycle is ignored.
- R8: The level flag is high exactly when the occupancy is strictly greater than the 3-bit threshold. A threshold of 0 flags a single entry.
- R9: The interrupt output equals the level flag ANDed with the interrupt enable input, within the same cycle.
- R10: The occupancy output equals the number of entries that are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Write strobe from the sequencer |
| push_value_i | input | 16 | Conversion value to store |
| push_cmd_i | input | 3 | Command tag |
| push_loop_i | input | 4 | Loop index tag |
| push_trig_i | input | 2 | Trigger tag |
| pop_i | input | 1 | Read strobe; removes the head entry |
| flush_i | input | 1 | Discard all entries and clear overflow |
| thresh_i | input | 3 | Level threshold |
| lvl_irq_en_i | input | 1 | Interrupt enable |
| head_valid_o | output | 1 | Head entry is valid |
| head_value_o | output | 16 | Head conversion value |
| head_cmd_o | output | 3 | Head command tag |
| head_loop_o | output | 4 | Head loop tag |
| head_trig_o | output | 2 | Head trigger tag |
| fill_o | output | 4 | Occupancy count |
| lvl_flag_o | output | 1 | Occupancy above threshold |
| irq_o | output | 1 | Gated level interrupt |
| overrun_o | output | 1 | Sticky dropped-write flag |

## Verification
Occupancy, overflow, valid and head contents all come from registers, so their response to a strobe appears one rising edge later. The level flag and the interrupt are combinational in the threshold and the enable, so they respond within the same cycle as those inputs, and one edge after a change in occupancy. The bench drives every input on the falling edge and compares all outputs 1 ns later against a queue-based model. The model is advanced right after each rising edge, so each comparison sees exactly one edge of history.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
    localparam int TF_DEPTH  = 8;
    localparam int TF_VAL_W  = 16;
    localparam int TF_CMD_W  = 3;
    localparam int TF_LOOP_W = 4;
    localparam int TF_TRIG_W = 2;
    localparam int TF_THR_W  = 3;

    function automatic int tf_cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic             take_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] fill_o,
    output logic             overrun_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  take_d, drop_d;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        take_d = 1'b0;
        drop_d = 1'b0;
        if (flush_i) begin
            st_d = '0;
        end else begin
            drop_d = pop_i && (st_q.cnt != '0);
            take_d = push_i && (st_q.cnt != CNT_W'(DEPTH));
            if (drop_d) st_d.rp = nxt(st_q.rp);
            if (take_d) st_d.wp = nxt(st_q.wp);
            if (push_i && !take_d) st_d.ovr = 1'b1;
            st_d.cnt = st_q.cnt + CNT_W'(take_d) - CNT_W'(drop_d);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o    = take_d;
    assign wr_ptr_o  = st_q.wp;
    assign rd_ptr_o  = st_q.rp;
    assign fill_o    = st_q.cnt;
    assign overrun_o = st_q.ovr;

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !flush_i) |=> overrun_o);
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == CNT_W'(DEPTH) && push_i && !pop_i && !flush_i)
        |=> (fill_o == CNT_W'(DEPTH)) && overrun_o);
    p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 25,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [ENT_W-1:0] wr_ent_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output logic [ENT_W-1:0] rd_ent_o
);
    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (take_i) mem_d[wr_ptr_i] = wr_ent_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_ent_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/tfifo_level.sv
module tfifo_level #(
    parameter int CNT_W = 4,
    parameter int THR_W = 3,
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_i,
    input  logic [THR_W-1:0] thresh_i,
    input  logic             irq_en_i,
    output logic             flag_o,
    output logic             irq_o
);
    logic [CMP_W-1:0] fill_x, thr_x;

    always_comb begin
        fill_x = CMP_W'(fill_i);
        thr_x  = CMP_W'(thresh_i);
        flag_o = fill_x > thr_x;
        irq_o  = flag_o && irq_en_i;
    end

    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);
    p_empty_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i == '0) |-> !flag_o);
endmodule

// File: rtl/tagged_result_fifo.sv
module tagged_result_fifo
    import tfifo_pkg::*;
#(
    parameter int DEPTH  = TF_DEPTH,
    parameter int VAL_W  = TF_VAL_W,
    parameter int CMD_W  = TF_CMD_W,
    parameter int LOOP_W = TF_LOOP_W,
    parameter int TRIG_W = TF_TRIG_W,
    parameter int THR_W  = TF_THR_W,
    localparam int ENT_W = VAL_W + CMD_W + LOOP_W + TRIG_W,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [VAL_W-1:0]  push_value_i,
    input  logic [CMD_W-1:0]  push_cmd_i,
    input  logic [LOOP_W-1:0] push_loop_i,
    input  logic [TRIG_W-1:0] push_trig_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic [THR_W-1:0]  thresh_i,
    input  logic              lvl_irq_en_i,
    output logic              head_valid_o,
    output logic [VAL_W-1:0]  head_value_o,
    output logic [CMD_W-1:0]  head_cmd_o,
    output logic [LOOP_W-1:0] head_loop_o,
    output logic [TRIG_W-1:0] head_trig_o,
    output logic [CNT_W-1:0]  fill_o,
    output logic              lvl_flag_o,
    output logic              irq_o,
    output logic              overrun_o
);
    logic             take;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [ENT_W-1:0] wr_ent, rd_ent;

    assign wr_ent = {push_trig_i, push_loop_i, push_cmd_i, push_value_i};

    tfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .flush_i(flush_i), .take_o(take), .wr_ptr_o(wr_ptr),
        .rd_ptr_o(rd_ptr), .fill_o(fill_o), .overrun_o(overrun_o)
    );

    tfifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .take_i(take), .wr_ptr_i(wr_ptr),
        .wr_ent_i(wr_ent), .rd_ptr_i(rd_ptr), .rd_ent_o(rd_ent)
    );

    tfifo_level #(.CNT_W(CNT_W), .THR_W(THR_W)) u_level (
        .clk(clk), .rst_n(rst_n), .fill_i(fill_o), .thresh_i(thresh_i),
        .irq_en_i(lvl_irq_en_i), .flag_o(lvl_flag_o), .irq_o(irq_o)
    );

    assign head_valid_o = (fill_o != '0);
    assign {head_trig_o, head_loop_o, head_cmd_o, head_value_o} = rd_ent;

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fill_o == '0) && !overrun_o && !head_valid_o);
    p_rw_keeps_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i && fill_o != '0 && fill_o != CNT_W'(DEPTH))
        |=> $stable(fill_o));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == '0 && pop_i && !push_i && !flush_i) |=> (fill_o == '0));
    p_pop_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !flush_i && head_valid_o) |=> (fill_o == $past(fill_o) - 1'b1));
endmodule

// File: tb/tagged_result_fifo_tb.sv
module tagged_result_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0, pop = 1'b0, flush = 1'b0, ien = 1'b0;
    logic [15:0] pv = '0;
    logic [2:0]  pc = '0;
    logic [3:0]  pl = '0;
    logic [1:0]  pt = '0;
    logic [2:0]  thr = '0;
    logic        hv, flag, irq, ovr;
    logic [15:0] hval;
    logic [2:0]  hcmd;
    logic [3:0]  hloop;
    logic [1:0]  htrig;
    logic [3:0]  fill;

    int compared = 0, mismatched = 0, seq = 0;
    bit done = 0;
    logic [24:0] mq[$];
    bit m_ovr = 0;

    always #5 clk = ~clk;

    tagged_result_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_value_i(pv),
        .push_cmd_i(pc), .push_loop_i(pl), .push_trig_i(pt), .pop_i(pop),
        .flush_i(flush), .thresh_i(thr), .lvl_irq_en_i(ien),
        .head_valid_o(hv), .head_value_o(hval), .head_cmd_o(hcmd),
        .head_loop_o(hloop), .head_trig_o(htrig), .fill_o(fill),
        .lvl_flag_o(flag), .irq_o(irq), .overrun_o(ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int n = mq.size();
        chk("R10 fill", 32'(fill), 32'(n));
        chk(n == 0 ? "R4 valid" : "R3 valid", 32'(hv), 32'(n != 0));
        if (n != 0) chk("R2 head entry", 32'({htrig, hloop, hcmd, hval}), 32'(mq[0]));
        chk("R6 overrun", 32'(ovr), 32'(m_ovr));
        chk("R8 level flag", 32'(flag), 32'(n > int'(thr)));
        chk("R9 irq", 32'(irq), 32'((n > int'(thr)) && ien));
    endtask

    task automatic set_entry();
        pv = 16'hA000 ^ 16'(seq * 16'h1357);
        pc = 3'(seq);
        pl = 4'(seq * 3);
        pt = 2'(seq >> 1);
        seq++;
    endtask

    // Inputs already driven at a falling edge; compare, cross one rising edge, advance model.
    task automatic cyc();
        bit full;
        #1 compare_all();
        @(posedge clk);
        if (flush) begin
            mq.delete();
            m_ovr = 0;
        end else begin
            full = (mq.size() == 8);
            if (pop && mq.size() != 0) void'(mq.pop_front());
            if (push) begin
                if (full) m_ovr = 1;
                else mq.push_back({pt, pl, pc, pv});
            end
        end
        @(negedge clk);
        push = 0; pop = 0; flush = 0;
    endtask

    task automatic wr();
        set_entry(); push = 1; cyc();
    endtask

    task automatic rd();
        pop = 1; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1;
        chk("R1 fill", 32'(fill), 0);
        chk("R1 valid", 32'(hv), 0);
        chk("R1 overrun", 32'(ovr), 0);
        chk("R1 flag", 32'(flag), 0);
        chk("R1 irq", 32'(irq), 0);
        @(negedge clk);

        // R4 pop on empty
        rd(); rd();
        // R8 threshold 0 flags a single entry, R9 gating
        thr = 0; ien = 0; wr();
        cyc();
        ien = 1; cyc();
        ien = 0; cyc();
        rd();
        // R2/R3 fill to depth with varied tags, threshold sweep
        ien = 1;
        for (int i = 0; i < 8; i++) begin thr = 3'(i); wr(); end
        for (int t = 0; t < 8; t++) begin thr = 3'(t); cyc(); end
        // R6 write while full, alone and with a read
        wr();
        set_entry(); push = 1; pop = 1; cyc();
        cyc();
        // R2 drain in order
        for (int i = 0; i < 4; i++) rd();
        // R5 simultaneous read and write mid-level
        for (int i = 0; i < 6; i++) begin set_entry(); push = 1; pop = 1; cyc(); end
        // R6 overrun remains set across reads
        rd(); rd();
        // R7 flush with concurrent write and read
        set_entry(); push = 1; pop = 1; flush = 1; cyc();
        cyc();
        // R7 flush on empty, then refill and flush
        flush = 1; cyc();
        wr(); wr(); wr();
        flush = 1; cyc();
        // R4 simultaneous read and write on empty: write lands
        set_entry(); push = 1; pop = 1; cyc();
        rd();
        // wrap-around traffic
        for (int k = 0; k < 20; k++) begin
            thr = 3'(k);
            ien = k[0];
            set_entry(); push = (k % 3) != 2; pop = (k % 4) == 1; cyc();
        end
        for (int i = 0; i < 10; i++) rd();
        cyc();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule